// File: doc/BRIEF.md
# Dual-Class Interrupt Priority Arbiter

This block sits inside an interrupt controller and chooses, for each of two request classes, the single interrupt line that should be serviced next. The surrounding controller owns the pending bits, mask bits, class-select bits and per-line priority table, and presents them as flat vectors covering up to three banks of 32 lines. The arbiter filters the lines that may take part in each class, finds the most urgent one, and on a compute strobe stores one winner per class: a line number and a valid flag.

The same pending and mask vectors feed both classes. A per-line class bit sends each line either to the normal class or to the fast class, so the two results are independent. Urgency is a small number, where zero is the most urgent. Among lines of equal urgency the one with the highest global number wins. When no line qualifies, the class reports line zero with its valid flag low.

The number of populated banks is a parameter. Ports always cover the largest configuration, and input bits of banks that are not populated are ignored. Each bank can be scanned by a linear chain or by a balanced comparison tree. A parameter picks the variant, and both give the same result.

Top module: `dual_class_arbiter`

## Requirements
- R1: A line is a candidate for a class only when its pending bit is 1, its mask bit is 0, and its class bit matches the class: class bit 1 means fast class, class bit 0 means normal class.
- R2: Among candidates, the one with the numerically smallest priority value wins.
- R3: Among candidates that share the smallest priority value, the one with the highest global line number wins.
- R4: Global line n uses bit n of the pending, mask and class vectors. The reported line number is 32 x bank + bit position in the bank.
- R5: When a class has no candidate, its valid output is 0 and its line output is 0.
- R6: The normal and fast results are computed independently from the shared pending and mask vectors. A line assigned to one class never shows up as the winner of the other.
- R7: Results are captured at the clock edge where `compute` is 1 and appear in the cycle after that edge. When `compute` is 0, both results hold their values.
- R8: Lines in banks at or above `NUM_BANKS` are never candidates, whatever their input bits.
- R9: After reset, both valid outputs are 0 and both line outputs are 0.
- R10: A lone candidate with the all-ones priority value still wins.
- R11: The priority of line n is taken from bits [n x PRIO_W +: PRIO_W] of the priority vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| compute | input | 1 | Strobe that captures a new result for both classes |
| pending | input | 96 | Pending bit per global line |
| mask | input | 96 | Mask bit per line; 1 blocks the line |
| class_sel | input | 96 | Class bit per line; 1 fast, 0 normal |
| prio | input | 96 x PRIO_W | Priority value per line, packed by line number |
| irq_line | output | 7 | Winning line of the normal class |
| irq_valid | output | 1 | Normal class has a winner |
| fiq_line | output | 7 | Winning line of the fast class |
| fiq_valid | output | 1 | Fast class has a winner |

## Verification
The checker tests the following properties at every clock edge:
- When valid is low, the line output is zero.
- Outputs hold their values whenever no strobe is present.
- Each valid flag matches whether its class had any candidate at the last strobe.
- A reported winner was a candidate of its own class.
- A reported winner lies inside the populated banks.

The rule that the lowest value wins and the highest line wins a tie can only be shown by the bench. It sweeps single lines across every bank, builds full ties, splits the lines between the two classes, and compares many mixed patterns with an arithmetic model.

// File: rtl/intarb_pkg.sv
package intarb_pkg;

   localparam int MAX_BANKS  = 3;
   localparam int BANK_LINES = 32;
   localparam int MAX_LINES  = MAX_BANKS * BANK_LINES;
   localparam int LINE_W     = $clog2(MAX_LINES);
   localparam int IDX_W      = $clog2(BANK_LINES);

   typedef enum logic {
      CLASS_NORMAL = 1'b0,
      CLASS_FAST   = 1'b1
   } req_class_e;

   typedef struct packed {
      logic              found;
      logic [LINE_W-1:0] line;
   } winner_t;

endpackage

// File: rtl/intarb_qualify.sv
module intarb_qualify
   import intarb_pkg::*;
#(
   parameter int         NUM_BANKS = 3,
   parameter req_class_e CLS       = CLASS_NORMAL
) (
   input  logic [MAX_LINES-1:0] pending,
   input  logic [MAX_LINES-1:0] mask,
   input  logic [MAX_LINES-1:0] class_sel,
   output logic [MAX_LINES-1:0] cand
);

   localparam int LIVE = NUM_BANKS * BANK_LINES;

   logic [MAX_LINES-1:0] class_match;

   generate
      if (CLS == CLASS_FAST) begin : g_fast
         assign class_match = class_sel;
      end else begin : g_norm
         assign class_match = ~class_sel;
      end
   endgenerate

   genvar gl;
   generate
      for (gl = 0; gl < MAX_LINES; gl++) begin : g_line
         if (gl < LIVE) begin : g_live
            assign cand[gl] = pending[gl] & ~mask[gl] & class_match[gl];
         end else begin : g_dead
            assign cand[gl] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/intarb_bank_scan.sv
module intarb_bank_scan
   import intarb_pkg::*;
#(
   parameter int PRIO_W    = 6,
   parameter bit SCAN_TREE = 1'b1
) (
   input  logic [BANK_LINES-1:0]        cand,
   input  logic [BANK_LINES*PRIO_W-1:0] prio,
   output logic                         found,
   output logic [IDX_W-1:0]             idx,
   output logic [PRIO_W-1:0]            best
);

   localparam logic [PRIO_W-1:0] P_MAX = '1;

   generate
      if (SCAN_TREE) begin : g_tree
         localparam int NODES = 2 * BANK_LINES;
         logic [PRIO_W-1:0] np [NODES];
         logic [IDX_W-1:0]  ni [NODES];
         logic              nv [NODES];

         always_comb begin
            np[0] = P_MAX;
            ni[0] = '0;
            nv[0] = 1'b0;
            for (int i = 0; i < BANK_LINES; i++) begin
               nv[BANK_LINES+i] = cand[i];
               np[BANK_LINES+i] = cand[i] ? prio[i*PRIO_W +: PRIO_W] : P_MAX;
               ni[BANK_LINES+i] = IDX_W'(i);
            end
            for (int n = BANK_LINES - 1; n >= 1; n--) begin
               // right child always covers higher line numbers
               if (nv[2*n+1] && (!nv[2*n] || (np[2*n+1] <= np[2*n]))) begin
                  np[n] = np[2*n+1];
                  ni[n] = ni[2*n+1];
               end else begin
                  np[n] = np[2*n];
                  ni[n] = ni[2*n];
               end
               nv[n] = nv[2*n] | nv[2*n+1];
            end
         end

         assign found = nv[1];
         assign idx   = nv[1] ? ni[1] : '0;
         assign best  = np[1];
      end else begin : g_chain
         always_comb begin
            found = 1'b0;
            idx   = '0;
            best  = P_MAX;
            for (int i = 0; i < BANK_LINES; i++) begin
               if (cand[i] && (prio[i*PRIO_W +: PRIO_W] <= best)) begin
                  best  = prio[i*PRIO_W +: PRIO_W];
                  idx   = IDX_W'(i);
                  found = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/intarb_bank_merge.sv
module intarb_bank_merge
   import intarb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6
) (
   input  logic [NUM_BANKS-1:0]        bank_found,
   input  logic [NUM_BANKS*IDX_W-1:0]  bank_idx,
   input  logic [NUM_BANKS*PRIO_W-1:0] bank_best,
   output winner_t                     win
);

   logic [PRIO_W-1:0] best;

   always_comb begin
      win  = '0;
      best = '1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_found[b] && (bank_best[b*PRIO_W +: PRIO_W] <= best)) begin
            best      = bank_best[b*PRIO_W +: PRIO_W];
            win.found = 1'b1;
            win.line  = LINE_W'(b * BANK_LINES) + LINE_W'(bank_idx[b*IDX_W +: IDX_W]);
         end
      end
   end

endmodule

// File: rtl/dual_class_arbiter.sv
module dual_class_arbiter
   import intarb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6,
   parameter bit SCAN_TREE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        compute,
   input  logic [MAX_LINES-1:0]        pending,
   input  logic [MAX_LINES-1:0]        mask,
   input  logic [MAX_LINES-1:0]        class_sel,
   input  logic [MAX_LINES*PRIO_W-1:0] prio,
   output logic [LINE_W-1:0]           irq_line,
   output logic                        irq_valid,
   output logic [LINE_W-1:0]           fiq_line,
   output logic                        fiq_valid
);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..3");
      end
      if (PRIO_W != 5 && PRIO_W != 6) begin : g_bad_prio
         $error("PRIO_W must be 5 or 6");
      end
   endgenerate

   winner_t win_d [2];
   winner_t win_q [2];

   genvar gc, gb;
   generate
      for (gc = 0; gc < 2; gc++) begin : g_class
         localparam req_class_e CLS = (gc == 1) ? CLASS_FAST : CLASS_NORMAL;

         logic [MAX_LINES-1:0]        cand;
         logic [NUM_BANKS-1:0]        bfound;
         logic [NUM_BANKS*IDX_W-1:0]  bidx;
         logic [NUM_BANKS*PRIO_W-1:0] bbest;

         intarb_qualify #(.NUM_BANKS(NUM_BANKS), .CLS(CLS)) u_qual (
            .pending   (pending),
            .mask      (mask),
            .class_sel (class_sel),
            .cand      (cand)
         );

         for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            intarb_bank_scan #(.PRIO_W(PRIO_W), .SCAN_TREE(SCAN_TREE)) u_scan (
               .cand  (cand[gb*BANK_LINES +: BANK_LINES]),
               .prio  (prio[gb*BANK_LINES*PRIO_W +: BANK_LINES*PRIO_W]),
               .found (bfound[gb]),
               .idx   (bidx[gb*IDX_W +: IDX_W]),
               .best  (bbest[gb*PRIO_W +: PRIO_W])
            );
         end

         intarb_bank_merge #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) u_merge (
            .bank_found (bfound),
            .bank_idx   (bidx),
            .bank_best  (bbest),
            .win        (win_d[gc])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q[gc] <= '0;
            end else if (compute) begin
               win_q[gc] <= win_d[gc];
            end
         end
      end
   endgenerate

   assign irq_line  = win_q[0].line;
   assign irq_valid = win_q[0].found;
   assign fiq_line  = win_q[1].line;
   assign fiq_valid = win_q[1].found;

endmodule

// File: rtl/dual_class_arbiter_chk.sv
module dual_class_arbiter_chk
   import intarb_pkg::*;
#(
   parameter int NUM_BANKS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 compute,
   input logic [MAX_LINES-1:0] pending,
   input logic [MAX_LINES-1:0] mask,
   input logic [MAX_LINES-1:0] class_sel,
   input logic [LINE_W-1:0]    irq_line,
   input logic                 irq_valid,
   input logic [LINE_W-1:0]    fiq_line,
   input logic                 fiq_valid
);

   localparam int LIVE = NUM_BANKS * BANK_LINES;

   logic [MAX_LINES-1:0] live_bits;
   logic [MAX_LINES-1:0] nq_q, fq_q;

   always_comb begin
      for (int i = 0; i < MAX_LINES; i++) live_bits[i] = (i < LIVE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nq_q <= '0;
         fq_q <= '0;
      end else if (compute) begin
         nq_q <= pending & ~mask & ~class_sel & live_bits;
         fq_q <= pending & ~mask &  class_sel & live_bits;
      end
   end

   // R5
   irq_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_line == '0));
   // R5
   fiq_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fiq_valid |-> (fiq_line == '0));
   // R7
   hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !compute |=> ($stable(irq_line) && $stable(irq_valid) &&
                    $stable(fiq_line) && $stable(fiq_valid)));
   // R1
   irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      compute |=> (irq_valid == (|nq_q)));
   // R1
   fiq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      compute |=> (fiq_valid == (|fq_q)));
   // R8
   irq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (int'(irq_line) < LIVE));
   // R8
   fiq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_valid |-> (int'(fiq_line) < LIVE));
   // R6
   irq_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> nq_q[irq_line]);
   // R6
   fiq_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_valid |-> fq_q[fiq_line]);

endmodule

bind dual_class_arbiter dual_class_arbiter_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .compute   (compute),
   .pending   (pending),
   .mask      (mask),
   .class_sel (class_sel),
   .irq_line  (irq_line),
   .irq_valid (irq_valid),
   .fiq_line  (fiq_line),
   .fiq_valid (fiq_valid)
);

// File: tb/tb_dual_class_arbiter.sv
module tb_dual_class_arbiter;
   import intarb_pkg::*;

   localparam int NB   = 2;
   localparam int PW   = 5;
   localparam int LIVE = NB * BANK_LINES;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    compute = 1'b0;
   logic [MAX_LINES-1:0]    pend = '0, msk = '0, csel = '0;
   logic [MAX_LINES*PW-1:0] pri = '0;
   logic [LINE_W-1:0]       irq_line, fiq_line;
   logic                    irq_valid, fiq_valid;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   dual_class_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW), .SCAN_TREE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .compute(compute),
      .pending(pend), .mask(msk), .class_sel(csel), .prio(pri),
      .irq_line(irq_line), .irq_valid(irq_valid),
      .fiq_line(fiq_line), .fiq_valid(fiq_valid)
   );

   // expected {valid, line} from the requirements
   function automatic logic [LINE_W:0] model(input logic fast);
      logic              f = 1'b0;
      logic [PW-1:0]     b = '0;
      logic [LINE_W-1:0] w = '0;
      for (int l = 0; l < LIVE; l++) begin
         if (pend[l] && !msk[l] && (csel[l] == fast)) begin
            if (!f || pri[l*PW +: PW] <= b) begin
               f = 1'b1;
               b = pri[l*PW +: PW];
               w = LINE_W'(l);
            end
         end
      end
      return {f, w};
   endfunction

   task automatic check(input string tag, input logic gv, input logic [LINE_W-1:0] gl,
                        input logic ev, input logic [LINE_W-1:0] el);
      total++;
      if (gv !== ev || gl !== el) begin
         bad++;
         $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                  tag, gv, gl, ev, el);
      end
   endtask

   task automatic strobe();
      @(negedge clk);
      compute = 1'b1;
      @(negedge clk);
      compute = 1'b0;
   endtask

   task automatic check_model(input string tag);
      logic [LINE_W:0] en, ef;
      en = model(1'b0);
      ef = model(1'b1);
      check({tag, " normal"}, irq_valid, irq_line, en[LINE_W], en[LINE_W-1:0]);
      check({tag, " fast"},   fiq_valid, fiq_line, ef[LINE_W], ef[LINE_W-1:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 normal", irq_valid, irq_line, 1'b0, '0);
      check("R9 fast",   fiq_valid, fiq_line, 1'b0, '0);
      rst_n = 1'b1;

      // R4 R8 R6: every single line in both classes, including the absent bank
      for (int l = 0; l < MAX_LINES; l++) begin
         for (int c = 0; c < 2; c++) begin
            pend = '0; pend[l] = 1'b1;
            msk  = '0;
            csel = (c == 1) ? '1 : '0;
            pri  = '0;
            strobe();
            if (c == 0) begin
               check("R4 R8 normal", irq_valid, irq_line, l < LIVE, (l < LIVE) ? LINE_W'(l) : '0);
               check("R6 fast empty", fiq_valid, fiq_line, 1'b0, '0);
            end else begin
               check("R4 R8 fast", fiq_valid, fiq_line, l < LIVE, (l < LIVE) ? LINE_W'(l) : '0);
               check("R6 normal empty", irq_valid, irq_line, 1'b0, '0);
            end
         end
      end

      // R1 R5: everything masked
      pend = '1; msk = '1; csel = '0;
      strobe();
      check("R1 R5 masked", irq_valid, irq_line, 1'b0, '0);

      // R3: full tie, highest populated line wins
      msk = '0; csel = '0;
      for (int i = 0; i < MAX_LINES; i++) pri[i*PW +: PW] = PW'(7);
      strobe();
      check("R3 tie", irq_valid, irq_line, 1'b1, LINE_W'(LIVE - 1));

      // R2 R11: lower value beats higher line
      pend = '0; pri = '0;
      pend[3] = 1'b1; pri[3*PW +: PW] = PW'(1);
      pend[40] = 1'b1; pri[40*PW +: PW] = PW'(2);
      strobe();
      check("R2 R11 lower wins", irq_valid, irq_line, 1'b1, LINE_W'(3));

      // R10: lone all-ones priority
      pend = '0; pri = '0;
      pend[5] = 1'b1; pri[5*PW +: PW] = '1;
      strobe();
      check("R10 max prio", irq_valid, irq_line, 1'b1, LINE_W'(5));

      // R8: absent bank with urgent values is ignored
      pend = '0; pri = '1;
      pend[70] = 1'b1; pri[70*PW +: PW] = '0;
      pend[12] = 1'b1; pri[12*PW +: PW] = PW'(9);
      strobe();
      check("R8 absent bank", irq_valid, irq_line, 1'b1, LINE_W'(12));

      // R7: inputs change without strobe, outputs hold
      pend = '0; pend[20] = 1'b1; pri = '0;
      repeat (3) @(negedge clk);
      check("R7 hold", irq_valid, irq_line, 1'b1, LINE_W'(12));

      // R1 R2 R3 R6 R11: mixed patterns against the model
      for (int it = 0; it < 600; it++) begin
         for (int i = 0; i < MAX_LINES; i++) begin
            pend[i] = ($urandom_range(0, 3) != 0);
            msk[i]  = ($urandom_range(0, 3) == 0);
            csel[i] = $urandom_range(0, 1) != 0;
            pri[i*PW +: PW] = (it % 2 == 0) ? PW'($urandom_range(0, 3))
                                            : PW'($urandom_range(0, 31));
         end
         if (it % 50 == 0) msk = '1;
         strobe();
         check_model("R1 R2 R3 R6 R11 mix");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule